// File: doc/BRIEF.md
# Dual-Order 7:1 Serial Lane Packer

This block turns one pixel per pixel period into the bit stream of one port of a seven-to-one serial video link. Each pixel is a 24-bit RGB value plus horizontal sync, vertical sync and data-valid flags. The block splits it into four seven-bit data lane words and one clock-lane word. It then sends the words out one slot at a time, most significant slot first. A slot advances on each fast-clock cycle that has the shift enable set, so seven enabled cycles make one pixel period. A link with odd and even pixel ports uses two instances side by side.

A static select input chooses between two bit orderings. In the high-select ordering, the six low colour bits of each channel go on lanes 0 to 2, and the two top bits of each channel plus a reserved slot go on lane 3. In the low-select ordering, the two bottom bits of each channel go on lane 3, and the upper six bits move onto lanes 0 to 2. The block raises a take strobe on the enabled cycle that starts a new pixel period. The pixel inputs and the select are sampled on the clock edge ending that cycle, and on no other edge.

Top module: `lvds_packer`

## Requirements
- R1: While rst_n is low, every data lane and the clock lane output 0, whatever the other inputs do.
- R2: In each pixel period the clock lane sends 1,1,0,0,0,1,1, from the first slot to the last.
- R3: With fmt_sel = 1, the slots of each pixel are sent in this order, first slot on the left. Lane 0 sends G0,R5,R4,R3,R2,R1,R0. Lane 1 sends B1,B0,G5,G4,G3,G2,G1. Lane 2 sends DE,VS,HS,B5,B4,B3,B2. Lane 3 sends RSV,B7,B6,G7,G6,R7,R6. Bit 0 is the LSB of each channel.
- R4: With fmt_sel = 0, the order is as follows. Lane 0 sends G2,R7,R6,R5,R4,R3,R2. Lane 1 sends B3,B2,G7,G6,G5,G4,G3. Lane 2 sends DE,VS,HS,B7,B6,B5,B4. Lane 3 sends RSV,B1,B0,G1,G0,R1,R0.
- R5: The reserved slot RSV is always sent as the fixed level RSVD_LEVEL, which defaults to 0, in both orderings.
- R6: The outputs change only on clock edges where shift_en is high. With shift_en low, every lane output holds its value.
- R7: The pixel inputs are sampled only on the edge that ends a cycle with pix_take_o high. The first slot of that pixel appears right after that edge, and each later enabled edge shows the next slot. Pixel input values at other edges have no effect.
- R8: A change of fmt_sel in the middle of a pixel period leaves the slots of that pixel unchanged. The new ordering applies from the next take.
- R9: pix_take_o is high on the first enabled cycle after reset, and after that on every seventh enabled cycle. Exactly six enabled cycles without a take lie between two takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (slot-rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Fast-clock enable; one slot per enabled cycle |
| fmt_sel | input | 1 | Ordering select: 1 = top bits on lane 3, 0 = bottom bits on lane 3 |
| red_i | input | 8 | Red channel of the pixel |
| grn_i | input | 8 | Green channel of the pixel |
| blu_i | input | 8 | Blue channel of the pixel |
| hsync_i | input | 1 | Horizontal sync flag |
| vsync_i | input | 1 | Vertical sync flag |
| de_i | input | 1 | Data-valid flag |
| pix_take_o | output | 1 | High in the enabled cycle whose closing edge samples the pixel |
| lane_o | output | 4 | Serial data lanes 3..0 |
| clk_lane_o | output | 1 | Serial clock-lane bit |

## Verification
The assertions assume that shift_en is a clean synchronous enable. They also assume that the pixel and select inputs are settled before the edge that closes a take cycle. The stimulus changes every input half a cycle away from the active edge. It runs with the enable always high, with one cycle in three idle, and with one enabled cycle in four. While a pixel is being sent, it drives the pixel inputs with the inverted values and flips the select, then restores them before the next take. This shows that only the take edge samples the inputs.

// File: rtl/lvds_pack_pkg.sv
package lvds_pack_pkg;
    localparam int COLOR_W  = 8;
    localparam int LANE_CNT = 4;
    localparam int SLOT_CNT = 7;

    typedef logic [SLOT_CNT-1:0] slot_word_t;

    typedef enum logic {
        FMT_LOW_ON_L3  = 1'b0,
        FMT_HIGH_ON_L3 = 1'b1
    } order_e;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
        logic               hs;
        logic               vs;
        logic               de;
    } pixel_t;
endpackage

// File: rtl/lvds_lane_map.sv
module lvds_lane_map
    import lvds_pack_pkg::*;
#(
    parameter logic RSVD_LEVEL = 1'b0
) (
    input  pixel_t                          pix,
    input  order_e                          order,
    output logic [LANE_CNT-1:0][SLOT_CNT-1:0] words
);
    // index 0: bottom bits on lane 3, index 1: top bits on lane 3
    logic [1:0][LANE_CNT-1:0][SLOT_CNT-1:0] cand;

    for (genvar f = 0; f < 2; f++) begin : g_fmt
        localparam int BASE = (f == 1) ? 0 : 2;                 // first colour bit on lanes 0..2
        localparam int HB   = (f == 1) ? COLOR_W - 2 : 0;       // first colour bit on lane 3
        always_comb begin
            cand[f][0] = {pix.grn[BASE], pix.red[BASE+5:BASE]};
            cand[f][1] = {pix.blu[BASE+1:BASE], pix.grn[BASE+5:BASE+1]};
            cand[f][2] = {pix.de, pix.vs, pix.hs, pix.blu[BASE+5:BASE+2]};
            cand[f][3] = {RSVD_LEVEL, pix.blu[HB+1:HB], pix.grn[HB+1:HB], pix.red[HB+1:HB]};
        end
    end

    always_comb begin
        words = (order == FMT_HIGH_ON_L3) ? cand[1] : cand[0];
    end
endmodule

// File: rtl/lvds_slot_ctr.sv
module lvds_slot_ctr
    import lvds_pack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    output logic take_o,
    output logic seg_start_o
);
    localparam int CW = $clog2(SLOT_CNT);
    localparam logic [CW-1:0] LAST = CW'(SLOT_CNT - 1);

    typedef struct packed {
        logic [CW-1:0] slot;
        logic          seg_start;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d           = ctr_q;
        take_o          = shift_en && (ctr_q.slot == LAST);
        ctr_d.seg_start = take_o;
        if (shift_en) begin
            ctr_d.slot = take_o ? '0 : ctr_q.slot + 1'b1;
        end
        seg_start_o = ctr_q.seg_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.slot      <= LAST;
            ctr_q.seg_start <= 1'b0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    // checker: count enabled cycles since the last take
    logic [CW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             gap_q <= LAST;
        else if (take_o)        gap_q <= '0;
        else if (shift_en)      gap_q <= gap_q + 1'b1;
    end

    assert_take_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (gap_q == LAST));
    assert_no_late_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !take_o) |-> (gap_q < LAST));
endmodule

// File: rtl/lvds_slot_ser.sv
module lvds_slot_ser
    import lvds_pack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       shift,
    input  slot_word_t din,
    output logic       dout
);
    typedef struct packed {
        slot_word_t word;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (load) begin
            ser_d.word = din;
        end else if (shift) begin
            ser_d.word = {ser_q.word[SLOT_CNT-2:0], 1'b0};
        end
        dout = ser_q.word[SLOT_CNT-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(dout));
endmodule

// File: rtl/lvds_packer.sv
module lvds_packer
    import lvds_pack_pkg::*;
#(
    parameter logic             RSVD_LEVEL  = 1'b0,
    parameter logic [SLOT_CNT-1:0] CLK_PATTERN = 7'b1100011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               fmt_sel,
    input  logic [COLOR_W-1:0] red_i,
    input  logic [COLOR_W-1:0] grn_i,
    input  logic [COLOR_W-1:0] blu_i,
    input  logic               hsync_i,
    input  logic               vsync_i,
    input  logic               de_i,
    output logic               pix_take_o,
    output logic [LANE_CNT-1:0] lane_o,
    output logic               clk_lane_o
);
    pixel_t                          pix;
    order_e                          order;
    logic [LANE_CNT-1:0][SLOT_CNT-1:0] words;
    logic                            take;
    logic                            seg_start;

    always_comb begin
        pix   = '{red: red_i, grn: grn_i, blu: blu_i, hs: hsync_i, vs: vsync_i, de: de_i};
        order = order_e'(fmt_sel);
    end

    lvds_slot_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .take_o     (take),
        .seg_start_o(seg_start)
    );

    lvds_lane_map #(.RSVD_LEVEL(RSVD_LEVEL)) u_map (
        .pix  (pix),
        .order(order),
        .words(words)
    );

    for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
        lvds_slot_ser u_ser (
            .clk  (clk),
            .rst_n(rst_n),
            .load (take),
            .shift(shift_en),
            .din  (words[l]),
            .dout (lane_o[l])
        );
    end

    lvds_slot_ser u_clk_ser (
        .clk  (clk),
        .rst_n(rst_n),
        .load (take),
        .shift(shift_en),
        .din  (CLK_PATTERN),
        .dout (clk_lane_o)
    );

    assign pix_take_o = take;

    assert_clk_first_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start |-> (clk_lane_o == CLK_PATTERN[SLOT_CNT-1]));
    assert_rsvd_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start |-> (lane_o[LANE_CNT-1] == RSVD_LEVEL));
    assert_lanes_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(lane_o) && $stable(clk_lane_o)));
endmodule

// File: tb/lvds_packer_test.sv
module lvds_packer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0;
    logic       fmt_sel = 1'b1;
    logic [7:0] red_i = '0, grn_i = '0, blu_i = '0;
    logic       hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
    logic       pix_take_o;
    logic [3:0] lane_o;
    logic       clk_lane_o;

    always #4 clk = ~clk;

    lvds_packer uut (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .fmt_sel(fmt_sel),
        .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
        .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
        .pix_take_o(pix_take_o), .lane_o(lane_o), .clk_lane_o(clk_lane_o)
    );

    typedef struct packed {
        logic [3:0] lanes;
        logic       clkb;
    } exp_t;

    exp_t  exq[$];
    string tagq[$];
    int    checks = 0;
    int    failures = 0;
    int    mode = 0;
    int    cyc = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;

    task automatic report;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    function automatic logic [6:0] exp_word(int lane, bit f, logic [7:0] r, logic [7:0] g,
                                            logic [7:0] b, logic hs, logic vs, logic de);
        logic [6:0] w;
        if (f) begin
            case (lane)
                0: w = {g[0], r[5:0]};
                1: w = {b[1:0], g[5:1]};
                2: w = {de, vs, hs, b[5:2]};
                default: w = {1'b0, b[7:6], g[7:6], r[7:6]};
            endcase
        end else begin
            case (lane)
                0: w = {g[2], r[7:2]};
                1: w = {b[3:2], g[7:3]};
                2: w = {de, vs, hs, b[7:4]};
                default: w = {1'b0, b[1:0], g[1:0], r[1:0]};
            endcase
        end
        return w;
    endfunction

    // one driver cycle: inputs move at negedge+1
    task automatic step;
        @(negedge clk);
        #1;
        cyc++;
        case (mode)
            0: shift_en = 1'b1;
            1: shift_en = (cyc % 3) != 2;
            default: shift_en = (cyc % 4) == 0;
        endcase
    endtask

    task automatic send_pixel(input bit f, input logic [7:0] r, input logic [7:0] g,
                              input logic [7:0] b, input logic hs, input logic vs,
                              input logic de, input int scr, input string tag);
        logic [6:0] w [4];
        exp_t e;
        // mid-pixel disturbance: inverted pixel and flipped select (R7, R8)
        repeat (scr) begin
            step();
            red_i = ~r; grn_i = ~g; blu_i = ~b;
            hsync_i = ~hs; vsync_i = ~vs; de_i = ~de; fmt_sel = ~f;
        end
        forever begin
            step();
            red_i = r; grn_i = g; blu_i = b;
            hsync_i = hs; vsync_i = vs; de_i = de; fmt_sel = f;
            #1;
            if (pix_take_o) begin
                for (int l = 0; l < 4; l++) w[l] = exp_word(l, f, r, g, b, hs, vs, de);
                for (int s = 6; s >= 0; s--) begin
                    for (int l = 0; l < 4; l++) e.lanes[l] = w[l][s];
                    e.clkb = (7'b1100011 >> s) & 7'd1;
                    exq.push_back(e);
                    tagq.push_back(tag);
                end
                break;
            end
        end
    endtask

    // monitor / scoreboard
    logic       en_prev = 1'b0, take_prev = 1'b0;
    logic [3:0] snap_lanes = '0;
    logic       snap_clk = 1'b0;
    int         gap = 0;
    bit         first_take = 1'b1;

    always @(posedge clk) begin
        en_prev   <= shift_en;
        take_prev <= pix_take_o;
    end

    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (en_prev) begin
                checks++;
                if (exq.size() == 0) begin
                    failures++;
                    $display("FAIL R7 slot with no pixel queued: lanes=%b clk=%b expected none",
                             lane_o, clk_lane_o);
                end else begin
                    exp_t  e;
                    string t;
                    e = exq.pop_front();
                    t = tagq.pop_front();
                    if (lane_o !== e.lanes) begin
                        failures++;
                        $display("FAIL %s lanes=%b expected %b", t, lane_o, e.lanes);
                    end
                    checks++;
                    if (clk_lane_o !== e.clkb) begin
                        failures++;
                        $display("FAIL R2 clock lane=%b expected %b", clk_lane_o, e.clkb);
                    end
                end
            end else begin
                checks++;
                if (lane_o !== snap_lanes || clk_lane_o !== snap_clk) begin
                    failures++;
                    $display("FAIL R6 idle change lanes=%b clk=%b expected %b %b",
                             lane_o, clk_lane_o, snap_lanes, snap_clk);
                end
            end
            if (take_prev) begin
                if (!first_take) begin
                    checks++;
                    if (gap != 6) begin
                        failures++;
                        $display("FAIL R9 enables between takes=%0d expected 6", gap);
                    end
                end
                first_take = 1'b0;
                gap = 0;
            end else if (en_prev) begin
                gap++;
            end
        end
        snap_lanes = lane_o;
        snap_clk   = clk_lane_o;
    end

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired expected completion");
        report();
        $finish;
    end

    initial begin
        // R1: reset holds every lane low even with enable and data active
        shift_en = 1'b1;
        red_i = 8'hFF; grn_i = 8'hFF; blu_i = 8'hFF; de_i = 1'b1;
        repeat (6) begin
            @(negedge clk);
            checks++;
            if (lane_o !== 4'b0 || clk_lane_o !== 1'b0) begin
                failures++;
                $display("FAIL R1 reset lanes=%b clk=%b expected 0000 0", lane_o, clk_lane_o);
            end
        end
        #1;
        shift_en = 1'b0;
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        checks++;
        if (lane_o !== 4'b0 || clk_lane_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 after release lanes=%b clk=%b expected 0000 0", lane_o, clk_lane_o);
        end

        // R3 / R5: high-select ordering, continuous enable
        mode = 0;
        send_pixel(1'b1, 8'hA5, 8'h3C, 8'h0F, 1'b1, 1'b0, 1'b1, 0, "R3");
        send_pixel(1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 0, "R5");
        send_pixel(1'b1, 8'h01, 8'h80, 8'h42, 1'b0, 1'b1, 1'b0, 0, "R3");
        // R4: low-select ordering
        send_pixel(1'b0, 8'h5A, 8'hC3, 8'hF0, 1'b0, 1'b1, 1'b1, 0, "R4");
        send_pixel(1'b0, 8'h03, 8'h03, 8'h03, 1'b0, 1'b0, 1'b0, 0, "R4");
        send_pixel(1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 0, "R5");
        // R8: alternate selects at each boundary, gapped enable
        mode = 1;
        send_pixel(1'b1, 8'h96, 8'h69, 8'hE1, 1'b1, 1'b0, 1'b0, 0, "R8");
        send_pixel(1'b0, 8'h96, 8'h69, 8'hE1, 1'b1, 1'b0, 1'b0, 0, "R8");
        send_pixel(1'b1, 8'h12, 8'h34, 8'h56, 1'b0, 1'b0, 1'b1, 0, "R6");
        // R7 / R8: inputs disturbed while a pixel is in flight
        send_pixel(1'b0, 8'hC8, 8'h37, 8'h9B, 1'b0, 1'b1, 1'b1, 3, "R7");
        send_pixel(1'b1, 8'h6E, 8'hD1, 8'h2A, 1'b1, 1'b0, 1'b1, 3, "R8");
        mode = 2;
        send_pixel(1'b0, 8'h81, 8'h7E, 8'h18, 1'b1, 1'b1, 1'b0, 2, "R6");
        send_pixel(1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2, "R7");
        for (int i = 0; i < 6; i++) begin
            send_pixel(i[0], 8'(i * 37 + 5), 8'(i * 91 + 2), 8'(i * 13 + 200),
                       i[1], i[0], ~i[0], (i == 0) ? 0 : 1, "R9");
        end

        // drain, then R6/R7: idle enable and disturbed inputs leave outputs held
        forever begin
            @(negedge clk);
            #1;
            if (exq.size() == 0) begin
                shift_en = 1'b0;
                break;
            end
            shift_en = 1'b1;
        end
        red_i = 8'h55; grn_i = 8'hAA; fmt_sel = ~fmt_sel;
        repeat (5) @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end
endmodule